// File: doc/BRIEF.md
# Read Strobe Delay Trainer

This block calibrates the read-capture strobe delay of every byte lane of a DDR read path. For each lane it sweeps a small delay code upward from zero. At each code it reads back a fixed eight-byte training pattern, one byte at a time, through a single-outstanding read port. The first code at which all eight bytes compare equal opens the passing window. The engine then keeps stepping until a byte fails. The lane's delay is finally set to the middle of the window, and the read FIFO is flushed once more.

A single start pulse trains all lanes, one after the other in lane order. Reads flagged by the memory side as masked or dummy count as line noise and are repeated. A per-byte retry limit stops a line that is noisy all the time from stalling the engine. The block reports done together with exactly one of ok or error, and holds that result until the next start.

Top module: `strobe_train`

## Requirements
- R1: A start pulse accepted while idle or done clears every lane delay to 0. Lanes are then trained in ascending order, starting with lane 0.
- R2: The engine issues at most one read at a time. `rd_req_o` stays high, with `rd_lane_o` and `rd_idx_o` unchanged, until the cycle in which `rd_vld_i` is seen.
- R3: Every byte read is preceded by a one-cycle cycle in which both `fifo_rst_o` and `stat_clr_o` are high. `fifo_rst_o` is never high while `rd_req_o` is high.
- R4: A response with `rd_masked_i` or `rd_dummy_i` set is noise. It is not compared, the delay code is left unchanged, and the same byte index is read again.
- R5: Once RETRY_MAX consecutive noisy responses for one byte have been retried, the next noisy response ends training with an error. With the default of 255, that is the 256th noisy read.
- R6: The expected bytes for indices 0 to 7 on `rd_idx_o` are 0xFE, 0x11, 0x33, 0x55, 0x77, 0x99, 0xBB and 0xDD, checked in index order.
- R7: While searching, a mismatching byte raises the lane delay by 1 and restarts the check at index 0. If the delay is already at its maximum (31), training ends with an error.
- R8: The first delay at which all eight bytes match is recorded as the window start, and the same delay is then checked again in the window phase. In that phase, a full match raises the delay by 1 and repeats the check, or ends training with an error if the delay is already 31. The first mismatch closes the window.
- R9: When the window closes, the lane delay becomes start + ((current − start) >> 1), and `fifo_rst_o` pulses once more.
- R10: After reset, `done_o`, `ok_o`, `err_o`, `rd_req_o` and all delays are 0. At the end, `done_o` is high together with exactly one of `ok_o` or `err_o`, and both stay put until the next start. On an error, lanes not yet trained keep delay 0, and the failing lane keeps the delay it reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start training of all lanes |
| rd_req_o | output | 1 | Byte read request, held until accepted |
| rd_lane_o | output | LANE_W | Lane whose byte is requested |
| rd_idx_o | output | 3 | Pattern byte index requested |
| rd_vld_i | input | 1 | Read response valid |
| rd_data_i | input | 8 | Read response byte |
| rd_masked_i | input | 1 | Response carried masked data |
| rd_dummy_i | input | 1 | Response carried dummy data |
| fifo_rst_o | output | 1 | Read FIFO reset pulse |
| stat_clr_o | output | 1 | Sticky status clear pulse |
| dly_o | output | LANES*DLY_W | Per-lane delay codes, lane 0 in the low bits |
| done_o | output | 1 | Training finished |
| ok_o | output | 1 | All lanes trained |
| err_o | output | 1 | Training aborted |

## Verification
The hardest cases to reach from the ports are windows that touch the top of the delay range, where the error must come from the window phase rather than from the search, and a retry limit that runs out partway through a byte. The bench's memory model passes or fails each read according to a per-lane window that the bench chooses. It places windows at 0, at 30 and at 31, and leaves one lane with no window at all. The model can also inject any number of masked or dummy responses, up to a permanent stream of them, so that it can count the exact number of reads before the abort.

// File: rtl/strobe_train_pkg.sv
`timescale 1ns/1ps
package strobe_train_pkg;
   localparam int PAT_LEN = 8;
   localparam int IDX_W   = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PREP,
      ST_READ,
      ST_FINAL,
      ST_DONE
   } st_e;

   typedef enum logic {
      PH_SEEK,
      PH_HOLD
   } ph_e;
endpackage

// File: rtl/strobe_pat_gen.sv
`timescale 1ns/1ps
module strobe_pat_gen #(
   parameter int IDX_W = 3
) (
   input  logic [IDX_W-1:0] idx_i,
   output logic [7:0]       byte_o
);
   logic [7:0] odd;
   always_comb begin
      odd = 8'({idx_i, 1'b0}) - 8'd1;
      if (idx_i == '0) byte_o = 8'hFE;
      else             byte_o = odd * 8'h11;
   end
endmodule

// File: rtl/strobe_dly_bank.sv
`timescale 1ns/1ps
module strobe_dly_bank #(
   parameter int LANES  = 2,
   parameter int DLY_W  = 5,
   parameter int LANE_W = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr_i,
   input  logic                   ld_i,
   input  logic [LANE_W-1:0]      ld_lane_i,
   input  logic [DLY_W-1:0]       ld_val_i,
   output logic [LANES*DLY_W-1:0] dly_o
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            dly_o[g*DLY_W +: DLY_W] <= '0;
         else if (clr_i)
            dly_o[g*DLY_W +: DLY_W] <= '0;
         else if (ld_i && ld_lane_i == LANE_W'(g))
            dly_o[g*DLY_W +: DLY_W] <= ld_val_i;
      end
   end
endmodule

// File: rtl/strobe_retry_ctr.sv
`timescale 1ns/1ps
module strobe_retry_ctr #(
   parameter int LIMIT = 255
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic at_lim_o
);
   localparam int CNT_W = $clog2(LIMIT + 1);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (clr_i)              cnt <= '0;
      else if (inc_i && !at_lim_o) cnt <= cnt + 1'b1;
   end
   assign at_lim_o = (cnt == CNT_W'(LIMIT));
endmodule

// File: rtl/strobe_train.sv
`timescale 1ns/1ps
module strobe_train
   import strobe_train_pkg::*;
#(
   parameter int LANES     = 2,
   parameter int DLY_W     = 5,
   parameter int RETRY_MAX = 255,
   localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   output logic                   rd_req_o,
   output logic [LANE_W-1:0]      rd_lane_o,
   output logic [IDX_W-1:0]       rd_idx_o,
   input  logic                   rd_vld_i,
   input  logic [7:0]             rd_data_i,
   input  logic                   rd_masked_i,
   input  logic                   rd_dummy_i,
   output logic                   fifo_rst_o,
   output logic                   stat_clr_o,
   output logic [LANES*DLY_W-1:0] dly_o,
   output logic                   done_o,
   output logic                   ok_o,
   output logic                   err_o
);
   localparam logic [DLY_W-1:0]  DLY_MAX  = {DLY_W{1'b1}};
   localparam logic [LANE_W-1:0] LANE_TOP = LANE_W'(LANES - 1);
   localparam logic [IDX_W-1:0]  IDX_TOP  = IDX_W'(PAT_LEN - 1);

   if (LANES < 1 || LANES > 16) begin : g_bad_lanes
      $error("strobe_train: LANES out of range");
   end
   if (DLY_W < 2 || DLY_W > 8) begin : g_bad_dly
      $error("strobe_train: DLY_W out of range");
   end
   if (RETRY_MAX < 1) begin : g_bad_retry
      $error("strobe_train: RETRY_MAX must be positive");
   end

   st_e               st;
   ph_e               ph;
   logic [LANE_W-1:0] lane;
   logic [IDX_W-1:0]  idx;
   logic [DLY_W-1:0]  win_start;
   logic              ok_r, err_r;

   logic [7:0]        exp_byte;
   logic [DLY_W-1:0]  cur_dly, half_span, ld_val;
   logic              ld, accept, resp, noisy, hit, last, at_max, at_lim;

   strobe_pat_gen #(.IDX_W(IDX_W)) u_pat (
      .idx_i (idx),
      .byte_o(exp_byte)
   );

   strobe_dly_bank #(.LANES(LANES), .DLY_W(DLY_W), .LANE_W(LANE_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (accept),
      .ld_i     (ld),
      .ld_lane_i(lane),
      .ld_val_i (ld_val),
      .dly_o    (dly_o)
   );

   strobe_retry_ctr #(.LIMIT(RETRY_MAX)) u_retry (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (accept || (resp && !noisy)),
      .inc_i   (resp && noisy),
      .at_lim_o(at_lim)
   );

   always_comb begin
      accept    = start_i && (st == ST_IDLE || st == ST_DONE);
      resp      = (st == ST_READ) && rd_vld_i;
      noisy     = rd_masked_i || rd_dummy_i;
      hit       = (rd_data_i == exp_byte);
      last      = (idx == IDX_TOP);
      cur_dly   = dly_o[lane*DLY_W +: DLY_W];
      at_max    = (cur_dly == DLY_MAX);
      half_span = (cur_dly - win_start) >> 1;
      ld        = 1'b0;
      ld_val    = cur_dly + 1'b1;
      if (resp && !noisy && !at_max) begin
         if (!hit && ph == PH_SEEK)           ld = 1'b1;
         if (hit && last && ph == PH_HOLD)    ld = 1'b1;
      end
      if (st == ST_FINAL) begin
         ld     = 1'b1;
         ld_val = win_start + half_span;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         ph        <= PH_SEEK;
         lane      <= '0;
         idx       <= '0;
         win_start <= '0;
         ok_r      <= 1'b0;
         err_r     <= 1'b0;
      end else begin
         case (st)
            ST_IDLE, ST_DONE: if (accept) begin
               st    <= ST_PREP;
               ph    <= PH_SEEK;
               lane  <= '0;
               idx   <= '0;
               ok_r  <= 1'b0;
               err_r <= 1'b0;
            end
            ST_PREP: st <= ST_READ;
            ST_READ: if (rd_vld_i) begin
               if (noisy) begin
                  if (at_lim) begin err_r <= 1'b1; st <= ST_DONE; end
                  else st <= ST_PREP;
               end else if (!hit) begin
                  if (ph == PH_HOLD) st <= ST_FINAL;
                  else if (at_max) begin err_r <= 1'b1; st <= ST_DONE; end
                  else begin idx <= '0; st <= ST_PREP; end
               end else if (!last) begin
                  idx <= idx + 1'b1;
                  st  <= ST_PREP;
               end else if (ph == PH_SEEK) begin
                  win_start <= cur_dly;
                  ph        <= PH_HOLD;
                  idx       <= '0;
                  st        <= ST_PREP;
               end else if (at_max) begin
                  err_r <= 1'b1;
                  st    <= ST_DONE;
               end else begin
                  idx <= '0;
                  st  <= ST_PREP;
               end
            end
            ST_FINAL: begin
               if (lane == LANE_TOP) begin
                  ok_r <= 1'b1;
                  st   <= ST_DONE;
               end else begin
                  lane <= lane + 1'b1;
                  ph   <= PH_SEEK;
                  idx  <= '0;
                  st   <= ST_PREP;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign rd_req_o   = (st == ST_READ);
   assign rd_lane_o  = lane;
   assign rd_idx_o   = idx;
   assign fifo_rst_o = (st == ST_PREP) || (st == ST_FINAL);
   assign stat_clr_o = (st == ST_PREP);
   assign done_o     = (st == ST_DONE);
   assign ok_o       = ok_r;
   assign err_o      = err_r;
endmodule

// File: rtl/strobe_train_chk.sv
`timescale 1ns/1ps
module strobe_train_chk #(
   parameter int DLY_BITS = 10,
   parameter int LANE_W   = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                rd_req_o,
   input logic                rd_vld_i,
   input logic [LANE_W-1:0]   rd_lane_o,
   input logic [2:0]          rd_idx_o,
   input logic                rd_masked_i,
   input logic                rd_dummy_i,
   input logic                fifo_rst_o,
   input logic                stat_clr_o,
   input logic [DLY_BITS-1:0] dly_o,
   input logic                done_o,
   input logic                ok_o,
   input logic                err_o
);
   a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o && !rd_vld_i |=> rd_req_o && $stable(rd_lane_o) && $stable(rd_idx_o));

   a_r3_prep_before_read: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_req_o) |-> $past(fifo_rst_o) && $past(stat_clr_o));

   a_r3_no_flush_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rst_o |-> !rd_req_o);

   a_r4_noise_keeps_dly: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o && rd_vld_i && (rd_masked_i || rd_dummy_i) |=> $stable(dly_o));

   a_r10_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (ok_o != err_o));

   a_r10_verdict_held: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && $past(done_o) |-> $stable(ok_o) && $stable(err_o) && $stable(dly_o));
endmodule

bind strobe_train strobe_train_chk #(
   .DLY_BITS(LANES*DLY_W),
   .LANE_W  (LANE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_req_o   (rd_req_o),
   .rd_vld_i   (rd_vld_i),
   .rd_lane_o  (rd_lane_o),
   .rd_idx_o   (rd_idx_o),
   .rd_masked_i(rd_masked_i),
   .rd_dummy_i (rd_dummy_i),
   .fifo_rst_o (fifo_rst_o),
   .stat_clr_o (stat_clr_o),
   .dly_o      (dly_o),
   .done_o     (done_o),
   .ok_o       (ok_o),
   .err_o      (err_o)
);

// File: tb/strobe_train_bench.sv
`timescale 1ns/1ps
module strobe_train_bench;
   localparam int LANES = 2;
   localparam int DLY_W = 5;
   localparam int RMAX  = 255;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic rd_req, rd_vld = 1'b0, rd_masked = 1'b0, rd_dummy = 1'b0;
   logic [7:0] rd_data = 8'h00;
   logic [0:0] rd_lane;
   logic [2:0] rd_idx;
   logic fifo_rst, stat_clr, done, ok, err;
   logic [LANES*DLY_W-1:0] dly;

   always #2 clk = ~clk;

   strobe_train #(.LANES(LANES), .DLY_W(DLY_W), .RETRY_MAX(RMAX)) u_strobe_train (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .rd_req_o(rd_req), .rd_lane_o(rd_lane), .rd_idx_o(rd_idx),
      .rd_vld_i(rd_vld), .rd_data_i(rd_data), .rd_masked_i(rd_masked), .rd_dummy_i(rd_dummy),
      .fifo_rst_o(fifo_rst), .stat_clr_o(stat_clr), .dly_o(dly),
      .done_o(done), .ok_o(ok), .err_o(err));

   localparam logic [7:0] PAT [8] = '{8'hFE, 8'h11, 8'h33, 8'h55, 8'h77, 8'h99, 8'hBB, 8'hDD};

   // lo0, hi0, lo1, hi1, noise, ok, d0, d1
   localparam int NV = 6;
   localparam int VEC [NV][8] = '{
      '{ 4, 10,  0,  5, 0, 1,  7,  3},
      '{ 0,  0, 20, 29, 3, 1,  0, 25},
      '{12, 30, 31, 31, 0, 0, 21, 31},
      '{ 5, 31,  0,  9, 0, 0, 31,  0},
      '{40, -1,  0,  9, 0, 0, 31,  0},
      '{30, 30,  1,  2, 0, 1, 30,  2}
   };

   int n_chk = 0, n_fail = 0;
   int lo [2], hi [2];
   int noise_left = 0, reads = 0, wait_c = 0;
   int rst_since = 0, clr_since = 0;
   int r2_bad = 0, r3_bad = 0, r4_bad = 0;
   bit noisy_pend = 0, req_seen = 0;
   logic [LANES*DLY_W-1:0] snap;
   logic [0:0] pl;
   logic [2:0] pi;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // behavioural memory: passes a byte when the lane delay is inside [lo,hi]
   always @(negedge clk) begin
      if (fifo_rst) rst_since++;
      if (stat_clr) clr_since++;
      if (!rst_n) begin
         rd_vld = 0; rd_masked = 0; rd_dummy = 0; wait_c = 0; req_seen = 0;
      end else if (rd_vld) begin
         rd_vld = 0; rd_masked = 0; rd_dummy = 0;
         if (noisy_pend && dly != snap) r4_bad++;
         noisy_pend = 0;
      end else if (rd_req) begin
         if (req_seen && (rd_lane != pl || rd_idx != pi)) r2_bad++;
         req_seen = 1; pl = rd_lane; pi = rd_idx;
         if (wait_c >= 1) begin
            int ln, d;
            ln = int'(rd_lane);
            d  = int'(dly[ln*DLY_W +: DLY_W]);
            if (rst_since < 1 || clr_since < 1) r3_bad++;
            rst_since = 0; clr_since = 0;
            reads++;
            wait_c = 0; req_seen = 0;
            rd_vld = 1;
            if (noise_left > 0) begin
               noise_left--;
               rd_masked = noise_left[0];
               rd_dummy  = !noise_left[0];
               rd_data   = 8'h00;
               noisy_pend = 1; snap = dly;
            end else begin
               rd_data = (d >= lo[ln] && d <= hi[ln]) ? PAT[rd_idx] : (PAT[rd_idx] ^ 8'h24);
            end
         end else wait_c++;
      end else wait_c = 0;
   end

   task automatic run_until_done(input string req);
      int t = 0;
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      while (!done && t < 40000) begin @(negedge clk); t++; end
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL %s: actual no done expected done (watchdog)", req);
      end
   endtask

   initial begin
      lo[0] = 0; hi[0] = 31; lo[1] = 0; hi[1] = 31;
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 reset done", done, 0);
      check("R10 reset ok/err", {ok, err}, 0);
      check("R10 reset dly", dly, 0);
      check("R10 reset req", rd_req, 0);
      rst_n = 1;
      @(negedge clk);

      foreach (VEC[v]) begin
         lo[0] = VEC[v][0]; hi[0] = VEC[v][1]; lo[1] = VEC[v][2]; hi[1] = VEC[v][3];
         noise_left = VEC[v][4];
         run_until_done("R1");
         // R6 R7 R8 R9: window search and centre
         check($sformatf("R9 vec%0d ok", v), ok, VEC[v][5]);
         check($sformatf("R10 vec%0d err", v), err, 1 - VEC[v][5]);
         check($sformatf("R8 vec%0d lane0 dly", v), int'(dly[4:0]), VEC[v][6]);
         check($sformatf("R7 vec%0d lane1 dly", v), int'(dly[9:5]), VEC[v][7]);
         if (VEC[v][5] == 1) check($sformatf("R9 vec%0d final flush", v), rst_since >= 1, 1);
      end

      // R10 result held until next start
      repeat (6) @(negedge clk);
      check("R10 held done", done, 1);
      check("R10 held dly", int'(dly[9:5]), 2);

      // R1 restart clears delays; R5 permanent noise aborts after RMAX retries
      lo[0] = 3; hi[0] = 8; noise_left = 1000000; reads = 0;
      run_until_done("R5");
      check("R5 err on noise", err, 1);
      check("R5 read count", reads, RMAX + 1);
      check("R1 delays cleared by start", dly, 0);
      noise_left = 0;

      // R6 pattern order exercised again after abort
      run_until_done("R6");
      check("R6 retrain ok", ok, 1);
      check("R6 lane0 centre", int'(dly[4:0]), 3 + 3);

      check("R2 request stable", r2_bad, 0);
      check("R3 flush and clear before read", r3_bad, 0);
      check("R4 noise leaves delay", r4_bad, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule